// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped table that the fetch stage reads with the current fetch address. In the same cycle it reports whether that address is a known taken branch and, if so, where fetch should go next. When the table has no matching entry, the next fetch address is simply the current one plus 4. The table never predicts a branch as not taken. Any branch it holds counts as taken, so a hit alone means a redirect.

The resolve stage writes to the table when a branch completes. It presents the branch address, whether the branch was taken, its real destination, and a flag. The flag says the redirect from the table was wrong: the branch was missing but taken, present but not taken, or present with a stale destination. The table changes only when that flag is set. A taken branch installs or refreshes its entry, and in doing so it evicts whatever branch shared the slot. A branch that resolves not taken removes its own entry and leaves a different branch's entry in the same slot untouched.

Top module: `btb_table`

## Requirements
- R1: After reset every slot is empty, so every lookup misses and `lk_next_pc` equals `lk_pc + 4`.
- R2: On a miss, `lk_hit` is 0 and `lk_next_pc` is `lk_pc + 4`, combinationally in the same cycle.
- R3: The slot is chosen by `lk_pc[IDX_W+1:2]`, where IDX_W = log2(ENTRIES). The tag is the TAG_W bits just above the slot index. A hit needs a valid slot whose stored tag equals that field. Bits 1:0 and all bits above the tag are not compared. On a hit, `lk_next_pc` equals the stored destination in the same cycle.
- R4: An update with `up_valid`, `up_mispredict` and `up_taken` all at 1 stores the tag and `up_target` in the slot of `up_pc` and marks it valid. Lookups see the new entry from the first cycle after that clock edge.
- R5: Such a taken update overwrites a valid slot that holds a different tag. The previous branch then misses.
- R6: An update with `up_valid` and `up_mispredict` at 1 and `up_taken` at 0, whose address matches the valid slot, invalidates that slot.
- R7: A not-taken update whose tag does not match the slot's occupant leaves the slot unchanged.
- R8: An update with `up_mispredict` at 0, or with `up_valid` at 0, changes no slot.
- R9: A taken update for a branch already present replaces its stored destination with `up_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Fetch address is a stored taken branch |
| lk_target | output | PC_W | Stored destination of the hitting slot |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Branch was actually taken |
| up_target | input | PC_W | Actual destination of the branch |
| up_mispredict | input | 1 | Table's redirect for this branch was wrong |

## Verification
Lookup results are combinational. The bench therefore sets `lk_pc` away from the clock edge, waits one time unit and then compares hit and next address. Updates land on the next rising edge. Each update is driven at a falling edge and held across exactly one rising edge. Only after that does the bench sweep every slot, looking up both the expected occupant's tag and a differing tag against a model kept by the bench. This means every effect is checked in the first cycle it is due.

// File: rtl/btb_table.sv
module btb_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 8,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_mispredict
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TAG_LSB = 2 + IDX_W;
  localparam int TAG_TOP = TAG_LSB + TAG_W;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  wire [IDX_W-1:0] lk_idx = lk_pc[TAG_LSB-1:2];
  wire [TAG_W-1:0] lk_tag = lk_pc[TAG_TOP-1:TAG_LSB];
  wire [IDX_W-1:0] up_idx = up_pc[TAG_LSB-1:2];
  wire [TAG_W-1:0] up_tag = up_pc[TAG_TOP-1:TAG_LSB];

  assign lk_hit     = vld[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_target  = tgt_q[lk_idx];
  assign lk_next_pc = lk_hit ? lk_target : lk_pc + PC_W'(4);

  wire up_match = vld[up_idx] && (tag_q[up_idx] == up_tag);
  wire wr_en    = up_valid && up_mispredict && up_taken;
  wire drop_en  = up_valid && up_mispredict && !up_taken && up_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld <= '0;
    else if (wr_en)
      vld[up_idx] <= 1'b1;
    else if (drop_en)
      vld[up_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[up_idx] <= up_tag;
      tgt_q[up_idx] <= up_target;
    end
  end

  generate
    if (TAG_TOP < PC_W) begin : g_hi
      wire unused_bits = ^{lk_pc[1:0], lk_pc[PC_W-1:TAG_TOP], up_pc[1:0], up_pc[PC_W-1:TAG_TOP]};
    end else begin : g_nohi
      wire unused_bits = ^{lk_pc[1:0], up_pc[1:0]};
    end
  endgenerate

  AST_ALLOC_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(up_idx)] && tag_q[$past(up_idx)] == $past(up_tag)
              && tgt_q[$past(up_idx)] == $past(up_target)); // R4
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |=> !vld[$past(up_idx)]); // R6
  AST_OTHER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_mispredict && !up_taken && !up_match) |=> $stable(vld)); // R7
  AST_NO_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_valid && up_mispredict) |=> $stable(vld)); // R8
endmodule

// File: tb/test_btb_table.sv
module test_btb_table;
  localparam int ENTRIES = 16;
  localparam int TAG_W   = 8;
  localparam int PC_W    = 32;
  localparam int IDX_W   = 4;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
  logic up_valid = 0, up_taken = 0, up_mispredict = 0;
  logic lk_hit;
  logic [PC_W-1:0] lk_target, lk_next_pc;

  int checks = 0, failures = 0;
  logic             m_vld [ENTRIES];
  logic [TAG_W-1:0] m_tag [ENTRIES];
  logic [PC_W-1:0]  m_tgt [ENTRIES];

  btb_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PC_W(PC_W)) i_btb_table (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .lk_next_pc(lk_next_pc), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_target(up_target), .up_mispredict(up_mispredict));

  always #5 clk = ~clk;

  function automatic logic [PC_W-1:0] mk(input logic [17:0] hi, input logic [TAG_W-1:0] t, input int idx);
    return {hi, t, IDX_W'(idx), 2'b00};
  endfunction

  task automatic check_pc(input logic [PC_W-1:0] pc, input string req);
    int idx;
    logic eh;
    logic [PC_W-1:0] en;
    idx = int'(pc[5:2]);
    eh = m_vld[idx] && m_tag[idx] == pc[13:6];
    en = eh ? m_tgt[idx] : pc + 4;
    lk_pc = pc;
    #1;
    checks++;
    if (lk_hit !== eh || lk_next_pc !== en) begin
      failures++;
      $display("FAIL %s pc=%h hit=%b next=%h expected hit=%b next=%h", req, pc, lk_hit, lk_next_pc, eh, en);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < ENTRIES; i++) begin
      check_pc(mk(18'h0, m_tag[i], i), req);
      check_pc(mk(18'h0, m_tag[i] ^ 8'h5A, i), req);
    end
  endtask

  task automatic upd(input logic v, input logic [PC_W-1:0] pc, input logic tk,
                     input logic [PC_W-1:0] tg, input logic mis);
    int idx;
    idx = int'(pc[5:2]);
    @(negedge clk);
    up_valid = v; up_pc = pc; up_taken = tk; up_target = tg; up_mispredict = mis;
    @(posedge clk);
    if (v && mis) begin
      if (tk) begin
        m_vld[idx] = 1; m_tag[idx] = pc[13:6]; m_tgt[idx] = tg;
      end else if (m_vld[idx] && m_tag[idx] == pc[13:6]) begin
        m_vld[idx] = 0;
      end
    end
    @(negedge clk);
    up_valid = 0; up_mispredict = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      m_vld[i] = 0; m_tag[i] = 8'(i * 3); m_tgt[i] = '0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    sweep("R1");
    check_pc(32'h0000_0FFC, "R2");
    for (int i = 0; i < ENTRIES; i++) begin
      upd(1, mk(18'h0, 8'(i * 3), i), 1, 32'h0001_0000 + 32'(i) * 32'h44, 1);
      check_pc(mk(18'h0, 8'(i * 3), i), "R4");
    end
    sweep("R3");
    check_pc(mk(18'h2A5, 8'(9), 3), "R3 upper bits ignored");
    check_pc(mk(18'h0, 8'(9), 3) | 32'h3, "R3 low bits ignored");
    upd(1, mk(18'h0, 8'h77, 2), 1, 32'hDEAD_0000, 0);
    upd(0, mk(18'h0, 8'h78, 4), 1, 32'hBEEF_0000, 1);
    upd(1, mk(18'h0, 8'(15), 5), 0, 32'h0, 0);
    upd(0, mk(18'h0, 8'(15), 5), 0, 32'h0, 1);
    sweep("R8");
    upd(1, mk(18'h0, 8'(9), 3), 1, 32'h0000_ABC0, 1);
    check_pc(mk(18'h0, 8'(9), 3), "R9");
    upd(1, mk(18'h0, 8'hF0, 5), 0, 32'h0, 1);
    check_pc(mk(18'h0, 8'(15), 5), "R7");
    upd(1, mk(18'h0, 8'(15), 5), 0, 32'h0, 1);
    check_pc(mk(18'h0, 8'(15), 5), "R6");
    sweep("R6");
    upd(1, mk(18'h0, 8'hC3, 7), 1, 32'h0000_7770, 1);
    check_pc(mk(18'h0, 8'(21), 7), "R5 old branch misses");
    check_pc(mk(18'h0, 8'hC3, 7), "R5 new branch hits");
    upd(1, mk(18'h0, 8'h11, 5), 1, 32'h0000_5550, 1);
    sweep("R4");
    do_reset();
    sweep("R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule